// File: doc/BRIEF.md
# I2C Bus-Busy Monitor and Start/Stop Sequencer

This block is the control and status byte of an I2C master. It watches the SDA and SCL lines, which it samples through synchronisers, and keeps a busy flag that follows the start and stop conditions on the bus, no matter which master made them. Software asks for a start, a repeated start or a stop by writing a two-bit command into the byte. A sequencer then produces that waveform on the open-drain pull-down enables for SDA and SCL. Each step of the waveform lasts one half-period, set by a parameter.

The byte also reports the synchronised SDA and SCL levels. It holds a soft-reset bit that aborts the sequencer, and it hides the busy flag while the clock-synchronous serial format is selected. The busy flag keeps tracking the real lines at all times, because it is only ever inferred from edges on SCL and SDA.

Top module: `i2c_busmon_ctl`

## Requirements
- R1: After reset the byte reads 0x7D, and both pull-down enables (`sda_oe`, `scl_oe`) are 0.
- R2: Bit 7 (busy) is set when the synchronised SDA falls while SCL stays high, and cleared when SDA rises while SCL stays high. An SDA change while SCL is low leaves it unchanged.
- R3: A write with bit 7 = 1 and bit 6 = 0, while the sequencer is idle, first pulls SDA low with SCL released for HALF_CNT cycles. It then pulls both lines low and holds the bus. The lines change in the cycle that follows the write edge.
- R4: The same start write while the bus is held makes a repeated start. SDA is released with SCL low, then SCL is released, then SDA is pulled low, each for HALF_CNT cycles, after which the bus is held again.
- R5: A write with bit 7 = 0 and bit 6 = 0, while the bus is held, makes a stop. Both lines are low, then SCL is released, each for HALF_CNT cycles, after which both lines are released. The same write while the sequencer is idle has no effect.
- R6: Bit 6 always reads 1. A write with bit 6 = 1 never changes the line drive.
- R7: While `sync_mode` is 1, bit 7 reads 0. It shows the busy flag again when `sync_mode` returns to 0.
- R8: Bit 5 reads the SDA level and bit 3 reads the SCL level, each two clock edges after the pin changes. Bits 4, 2 and 0 always read 1.
- R9: Bit 1 is a soft reset that every write stores. From the cycle after it is stored, both lines are released and the sequencer is idle. Start requests are ignored while it is set, and it reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 selects the clock-synchronous serial format |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control/status byte read value |
| sda_in | input | 1 | SDA pin level |
| scl_in | input | 1 | SCL pin level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |

## Verification
If the sequencer state is wrong, the pull-down enables leave the expected half-period pattern in the first cycle after the command write, and the bench compares them against that pattern every cycle. If the edge detector holds a wrong busy value, bit 7 disagrees with a model of the line history within four cycles of the line change. A stuck soft reset or a wrong synchroniser depth shows at the readback at the exact sample the requirement names. Open-drain loopback means the sequencer's own waveforms also drive the busy flag.

// File: rtl/i2c_busmon_pkg.sv
package i2c_busmon_pkg;
   localparam int unsigned CTL_W    = 8;
   localparam int unsigned B_BUSY   = 7;
   localparam int unsigned B_REQN   = 6;
   localparam int unsigned B_SDAMON = 5;
   localparam int unsigned B_ONE4   = 4;
   localparam int unsigned B_SCLMON = 3;
   localparam int unsigned B_ONE2   = 2;
   localparam int unsigned B_SRST   = 1;
   localparam int unsigned B_ONE0   = 0;

   typedef enum logic [2:0] {
      G_IDLE      = 3'd0,
      G_ST_LOW    = 3'd1,
      G_HELD      = 3'd2,
      G_RS_SDAREL = 3'd3,
      G_RS_SCLREL = 3'd4,
      G_SP_LOW    = 3'd5,
      G_SP_SCLREL = 3'd6
   } gen_state_e;
endpackage

// File: rtl/i2c_busmon_sync.sv
module i2c_busmon_sync #(
   parameter int unsigned NLINES  = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] lines_in,
   output logic [NLINES-1:0] lines_out
);
   generate
      if (NLINES < 1) begin : g_bad_lines
         $error("i2c_busmon_sync: NLINES must be at least 1");
      end

      if (STAGES == 0) begin : g_bypass
         assign lines_out = lines_in;
      end else if (STAGES == 1) begin : g_single
         for (genvar l = 0; l < NLINES; l++) begin : g_line
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= RST_VAL;
               else        q <= lines_in[l];
            end
            assign lines_out[l] = q;
         end
      end else begin : g_chain
         for (genvar l = 0; l < NLINES; l++) begin : g_line
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= {STAGES{RST_VAL}};
               else        q <= {q[STAGES-2:0], lines_in[l]};
            end
            assign lines_out[l] = q[STAGES-1];
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_busmon_cond.sv
module i2c_busmon_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_s,
   input  logic scl_s,
   output logic busy
);
   logic sda_p;
   logic scl_p;
   logic start_seen;
   logic stop_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_p <= 1'b1;
         scl_p <= 1'b1;
      end else begin
         sda_p <= sda_s;
         scl_p <= scl_s;
      end
   end

   assign start_seen = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_seen  = scl_s & scl_p & ~sda_p & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy <= 1'b0;
      else if (start_seen) busy <= 1'b1;
      else if (stop_seen)  busy <= 1'b0;
   end

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(scl_s && !sda_s));

   // R2
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(scl_s && sda_s));
endmodule

// File: rtl/i2c_busmon_gen.sv
module i2c_busmon_gen
   import i2c_busmon_pkg::*;
#(
   parameter int unsigned HALF_CNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic req_start,
   input  logic req_stop,
   output logic sda_oe,
   output logic scl_oe
);
   localparam int unsigned CW   = (HALF_CNT > 2) ? $clog2(HALF_CNT) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CNT - 1);

   generate
      if (HALF_CNT < 2) begin : g_bad_half
         $error("i2c_busmon_gen: HALF_CNT must be at least 2");
      end
   endgenerate

   gen_state_e    state, state_d;
   logic [CW-1:0] cnt, cnt_d;
   logic          tick;
   logic          timed;
   logic          sda_d, scl_d;

   assign tick  = (cnt == LAST);
   assign timed = (state == G_ST_LOW)    || (state == G_RS_SDAREL) ||
                  (state == G_RS_SCLREL) || (state == G_SP_LOW)    ||
                  (state == G_SP_SCLREL);

   always_comb begin
      state_d = state;
      unique case (state)
         G_IDLE:      if (req_start) state_d = G_ST_LOW;
         G_ST_LOW:    if (tick) state_d = G_HELD;
         G_HELD: begin
            if (req_start)     state_d = G_RS_SDAREL;
            else if (req_stop) state_d = G_SP_LOW;
         end
         G_RS_SDAREL: if (tick) state_d = G_RS_SCLREL;
         G_RS_SCLREL: if (tick) state_d = G_ST_LOW;
         G_SP_LOW:    if (tick) state_d = G_SP_SCLREL;
         G_SP_SCLREL: if (tick) state_d = G_IDLE;
         default:     state_d = G_IDLE;
      endcase
      if (abort) state_d = G_IDLE;
   end

   always_comb begin
      if (state_d != state) cnt_d = '0;
      else if (timed)       cnt_d = cnt + 1'b1;
      else                  cnt_d = '0;
   end

   always_comb begin
      sda_d = (state_d == G_ST_LOW) || (state_d == G_HELD) ||
              (state_d == G_SP_LOW) || (state_d == G_SP_SCLREL);
      scl_d = (state_d == G_HELD) || (state_d == G_RS_SDAREL) ||
              (state_d == G_SP_LOW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= G_IDLE;
         cnt    <= '0;
         sda_oe <= 1'b0;
         scl_oe <= 1'b0;
      end else begin
         state  <= state_d;
         cnt    <= cnt_d;
         sda_oe <= sda_d;
         scl_oe <= scl_d;
      end
   end

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R3
   scl_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> sda_oe);

   // R9
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!sda_oe && !scl_oe));
endmodule

// File: rtl/i2c_busmon_ctl.sv
module i2c_busmon_ctl
   import i2c_busmon_pkg::*;
#(
   parameter int unsigned HALF_CNT    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_mode,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output logic [CTL_W-1:0] rd_data,
   input  logic             sda_in,
   input  logic             scl_in,
   output logic             sda_oe,
   output logic             scl_oe
);
   localparam int unsigned NLINES = 2;

   logic [NLINES-1:0] raw_lines;
   logic [NLINES-1:0] syn_lines;
   logic              sda_s, scl_s;
   logic              busy_int;
   logic              soft_rst_q;
   logic              cmd_ok;
   logic              req_start, req_stop;
   logic              unused_wr;

   assign raw_lines = {scl_in, sda_in};

   i2c_busmon_sync #(
      .NLINES  (NLINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines_in  (raw_lines),
      .lines_out (syn_lines)
   );

   assign sda_s = syn_lines[0];
   assign scl_s = syn_lines[1];

   i2c_busmon_cond i_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .sda_s (sda_s),
      .scl_s (scl_s),
      .busy  (busy_int)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     soft_rst_q <= 1'b0;
      else if (wr_en) soft_rst_q <= wr_data[B_SRST];
   end

   assign cmd_ok    = wr_en && !wr_data[B_REQN] && !wr_data[B_SRST] && !soft_rst_q;
   assign req_start = cmd_ok &&  wr_data[B_BUSY];
   assign req_stop  = cmd_ok && !wr_data[B_BUSY];

   i2c_busmon_gen #(
      .HALF_CNT (HALF_CNT)
   ) i_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (soft_rst_q),
      .req_start (req_start),
      .req_stop  (req_stop),
      .sda_oe    (sda_oe),
      .scl_oe    (scl_oe)
   );

   always_comb begin
      rd_data           = '0;
      rd_data[B_BUSY]   = busy_int & ~sync_mode;
      rd_data[B_REQN]   = 1'b1;
      rd_data[B_SDAMON] = sda_s;
      rd_data[B_ONE4]   = 1'b1;
      rd_data[B_SCLMON] = scl_s;
      rd_data[B_ONE2]   = 1'b1;
      rd_data[B_SRST]   = soft_rst_q;
      rd_data[B_ONE0]   = 1'b1;
   end

   assign unused_wr = ^{wr_data[B_SDAMON], wr_data[B_ONE4], wr_data[B_SCLMON],
                        wr_data[B_ONE2], wr_data[B_ONE0]};

   // R5
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[B_REQN] && !wr_data[B_BUSY] && !sda_oe && !scl_oe && !busy_int)
      |=> (!sda_oe && !scl_oe));

   // R6
   reqn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[B_REQN] && !soft_rst_q && !sda_oe && !scl_oe && !busy_int)
      |=> (!sda_oe && !scl_oe));

   // R9
   srst_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[B_SRST] == $past(wr_data[B_SRST])));
endmodule

// File: tb/test_i2c_busmon_ctl.sv
`timescale 1ns/1ps
module test_i2c_busmon_ctl;
   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_mode = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       sda_oe, scl_oe;
   logic       ext_sda = 1'b1;
   logic       ext_scl = 1'b1;
   logic       sda_in, scl_in;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;
   logic       busy_m;

   assign sda_in = ext_sda & ~sda_oe;
   assign scl_in = ext_scl & ~scl_oe;

   always #2.5 clk = ~clk;

   i2c_busmon_ctl #(.HALF_CNT(H), .SYNC_STAGES(2)) i_i2c_busmon_ctl (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .sda_in(sda_in), .scl_in(scl_in),
      .sda_oe(sda_oe), .scl_oe(scl_oe));

   function automatic logic [7:0] exp_rd(logic busy, logic sm, logic sda, logic scl, logic sr);
      return {busy & ~sm, 1'b1, sda, 1'b1, scl, 1'b1, sr, 1'b1};
   endfunction

   // kind 0 start, 1 repeated start, 2 stop; returns {sda_oe, scl_oe}
   function automatic logic [1:0] exp_oe(int kind, int i);
      if (kind == 0) return (i < H) ? 2'b10 : 2'b11;
      if (kind == 1) begin
         if (i < H)   return 2'b01;
         if (i < 2*H) return 2'b00;
         if (i < 3*H) return 2'b10;
         return 2'b11;
      end
      if (i < H)   return 2'b11;
      if (i < 2*H) return 2'b10;
      return 2'b00;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_n(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic run_seq(string req, int kind, logic [7:0] d);
      wr(d);
      for (int i = 0; i < 4*H; i++) begin
         check(req, {6'd0, sda_oe, scl_oe}, {6'd0, exp_oe(kind, i)});
         @(negedge clk);
      end
   endtask

   task automatic line_step(int which);
      if (which == 0) begin
         if (ext_scl) busy_m = ext_sda;
         ext_sda = ~ext_sda;
      end else begin
         ext_scl = ~ext_scl;
      end
      wait_n(4);
   endtask

   initial begin
      void'($urandom(32'h5EED));
      busy_m = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", rd_data, 8'h7D);
      check("R1", {6'd0, sda_oe, scl_oe}, 8'h00);

      // R8 monitor latency on SCL
      ext_scl = 1'b0;
      @(negedge clk);
      check("R8", rd_data, 8'h7D);
      @(negedge clk);
      check("R8", rd_data, 8'h75);
      ext_scl = 1'b1;
      wait_n(4);

      // R5 stop when idle is ignored
      wr(8'h00);
      for (int i = 0; i < 3*H; i++) begin
         check("R5", {6'd0, sda_oe, scl_oe}, 8'h00);
         @(negedge clk);
      end

      // R3 start
      run_seq("R3", 0, 8'h80);
      wait_n(4);
      check("R3", rd_data, exp_rd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0));

      // R7 busy masked in synchronous format
      sync_mode = 1'b1;
      @(negedge clk);
      check("R7", rd_data, exp_rd(1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
      sync_mode = 1'b0;
      @(negedge clk);
      check("R7", rd_data, exp_rd(1'b1, 1'b0, 1'b0, 1'b0, 1'b0));

      // R4 repeated start
      run_seq("R4", 1, 8'h80);
      wait_n(4);
      check("R4", rd_data, 8'hD5);

      // R5 stop
      run_seq("R5", 2, 8'h3C);
      wait_n(4);
      check("R5", rd_data, 8'h7D);

      // R9 soft reset aborts a start
      wr(8'h80);
      wait_n(3);
      wr(8'h42);
      @(negedge clk);
      check("R9", {6'd0, sda_oe, scl_oe}, 8'h00);
      wait_n(6);
      check("R9", rd_data, 8'h7F);
      wr(8'h82);
      for (int i = 0; i < 2*H; i++) begin
         check("R9", {6'd0, sda_oe, scl_oe}, 8'h00);
         @(negedge clk);
      end
      wr(8'h40);
      check("R9", rd_data, 8'h7D);

      // R2 directed: SDA change with SCL low leaves busy alone
      line_step(1);
      line_step(0);
      line_step(1);
      check("R2", rd_data, exp_rd(busy_m, 1'b0, ext_sda, ext_scl, 1'b0));
      line_step(0);
      check("R2", rd_data, exp_rd(busy_m, 1'b0, ext_sda, ext_scl, 1'b0));
      line_step(0);
      check("R2", rd_data, exp_rd(busy_m, 1'b0, ext_sda, ext_scl, 1'b0));

      // R2 R6 R8 random mix
      for (int n = 0; n < 60; n++) begin
         int unsigned r;
         r = $urandom % 3;
         if (r < 2) begin
            line_step(int'(r));
            check("R2/R8", rd_data, exp_rd(busy_m, 1'b0, ext_sda, ext_scl, 1'b0));
         end else begin
            wr(($urandom & 8'hFD) | 8'h40);
            wait_n(3);
            check("R6", {6'd0, sda_oe, scl_oe}, 8'h00);
            check("R6", rd_data, exp_rd(busy_m, 1'b0, ext_sda, ext_scl, 1'b0));
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule